// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash and decides when a program or erase already issued to the device has finished. It does this by reading one status location again and again. A request carries four things: the kind of operation, the byte that was written, the choice between the inverted-data check and the alternating-bit check, and a limit on the number of polling reads. The block then sends single-byte read requests through a simple request/response port. When it finishes it raises either a done pulse or a fail pulse.

A completion indicator on the status bits can be read in the same instant that the internal write finishes, and such a read can look valid when the data is not. For this reason an apparent completion is never accepted on its own. The poller reads the same location twice more. It reports done only when both of those bytes hold the full expected value. If either byte is wrong, the poller goes back to polling. The limit on polling reads ends a hung operation with a failure.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, busy_o, rd_req_o, done_o and fail_o are all low.
- R2: start_i is taken only while busy_o is low. At that point it captures op_erase_i, mode_toggle_i, exp_data_i and timeout_i, and busy_o rises on the next cycle. A start_i pulse while busy_o is high has no effect on the result of the operation or on the reads it issues.
- R3: At most one read is outstanding. rd_req_o stays high until a cycle in which rd_ready_i is high. No new request appears until rd_rsp_valid_i has returned the byte.
- R4: When mode_toggle_i is 0 and op_erase_i is 0 (program), a polling read is an apparent completion when its bit 7 equals bit 7 of exp_data_i.
- R5: When mode_toggle_i is 0 and op_erase_i is 1 (erase), a polling read is an apparent completion when its bit 7 is 1.
- R6: When mode_toggle_i is 1, a polling read is an apparent completion when its bit 6 equals bit 6 of the polling read just before it. The first polling read after a start, and the first after a rejection, is never an apparent completion.
- R7: After an apparent completion, exactly two confirming reads follow. The operation is done only if both bytes equal the target. The target is exp_data_i for a program and 8'hFF for an erase.
- R8: If either confirming byte differs from the target, the completion is rejected and polling resumes. The bit-6 history is cleared.
- R9: Only polling reads count toward the limit; confirming reads do not. A limit of 0 acts as 1. After a polling read that is not an apparent completion, or after a rejection, the block fails if the polling count has reached the limit. An apparent completion on the last allowed polling read still gets its two confirming reads.
- R10: done_o or fail_o is high for exactly one cycle, in the cycle after the final response. busy_o is low in that same cycle, and done_o and fail_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin waiting for an operation |
| op_erase_i | input | 1 | 1 for erase, 0 for program |
| mode_toggle_i | input | 1 | 1 selects the bit-6 alternation check, 0 the bit-7 check |
| exp_data_i | input | 8 | Byte that was programmed |
| timeout_i | input | TW | Maximum number of polling reads |
| rd_req_o | output | 1 | Read request to the status location |
| rd_ready_i | input | 1 | Read port accepts the request |
| rd_rsp_valid_i | input | 1 | Returned byte is valid |
| rd_rsp_data_i | input | 8 | Returned byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: completion confirmed |
| fail_o | output | 1 | One-cycle pulse: polling limit reached |

## Verification
A wrong phase or a corrupted bit-6 history shows up at the port in two ways. The number of reads issued before the result pulse changes, or the pulse flips between done and fail. Either effect appears within one or two response cycles of the fault. The bench models a device that stays busy for a chosen number of reads and optionally returns one corrupted byte at any position. It sweeps both operations, both checks, three expected bytes and three limits. For each case it compares the outcome and the exact count of reads against a model that walks the same byte sequence. A missing hold on the request or a second request in flight is caught at the read port in the cycle it happens.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          mode_toggle_i,
  input  logic [7:0]    exp_data_i,
  input  logic [TW-1:0] timeout_i,
  output logic          rd_req_o,
  input  logic          rd_ready_i,
  input  logic          rd_rsp_valid_i,
  input  logic [7:0]    rd_rsp_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);

  localparam logic [7:0] ERASED = 8'hFF;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t           st;
  logic [1:0]    phase;
  logic          conf_ok, have_prev, prev6, erase_q, tog_q;
  logic [7:0]    exp_q;
  logic [TW-1:0] lim_q, poll_cnt;

  wire [TW:0] lim     = (lim_q == '0) ? {{TW{1'b0}}, 1'b1} : {1'b0, lim_q};
  wire [TW:0] pc_next = {1'b0, poll_cnt} + {{TW{1'b0}}, 1'b1};
  wire [7:0]  tgt     = erase_q ? ERASED : exp_q;
  wire        match   = (rd_rsp_data_i == tgt);
  wire        dq7_hit = erase_q ? rd_rsp_data_i[7] : (rd_rsp_data_i[7] == exp_q[7]);
  wire        dq6_hit = have_prev && (rd_rsp_data_i[6] == prev6);
  wire        apparent = tog_q ? dq6_hit : dq7_hit;
  wire        rsp     = (st == S_WAIT) && rd_rsp_valid_i;

  assign rd_req_o = (st == S_REQ);
  assign busy_o   = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      phase     <= 2'd0;
      conf_ok   <= 1'b0;
      have_prev <= 1'b0;
      prev6     <= 1'b0;
      erase_q   <= 1'b0;
      tog_q     <= 1'b0;
      exp_q     <= '0;
      lim_q     <= '0;
      poll_cnt  <= '0;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          erase_q   <= op_erase_i;
          tog_q     <= mode_toggle_i;
          exp_q     <= exp_data_i;
          lim_q     <= timeout_i;
          poll_cnt  <= '0;
          phase     <= 2'd0;
          have_prev <= 1'b0;
          st        <= S_REQ;
        end
        S_REQ: if (rd_ready_i) st <= S_WAIT;
        S_WAIT: if (rsp) begin
          case (phase)
            2'd0: begin
              poll_cnt  <= pc_next[TW-1:0];
              prev6     <= rd_rsp_data_i[6];
              have_prev <= 1'b1;
              if (apparent) begin
                phase   <= 2'd1;
                conf_ok <= 1'b1;
                st      <= S_REQ;
              end else if (pc_next >= lim) begin
                fail_o <= 1'b1;
                st     <= S_IDLE;
              end else begin
                st <= S_REQ;
              end
            end
            2'd1: begin
              conf_ok <= conf_ok & match;
              phase   <= 2'd2;
              st      <= S_REQ;
            end
            default: begin
              phase     <= 2'd0;
              have_prev <= 1'b0;
              if (conf_ok && match) begin
                done_o <= 1'b1;
                st     <= S_IDLE;
              end else if ({1'b0, poll_cnt} >= lim) begin
                fail_o <= 1'b1;
                st     <= S_IDLE;
              end else begin
                st <= S_REQ;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));
  assert_result_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> !busy_o);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ready_i |=> rd_req_o);
  assert_no_req_in_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) && !rd_rsp_valid_i |=> !rd_req_o);
  assert_done_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rd_rsp_valid_i));
  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ({1'b0, poll_cnt} <= lim));
  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

endmodule

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb;
  localparam int TW = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, op_erase_i = 1'b0, mode_toggle_i = 1'b0;
  logic [7:0] exp_data_i = '0;
  logic [TW-1:0] timeout_i = '0;
  logic rd_req_o, rd_ready_i = 1'b0, rd_rsp_valid_i = 1'b0;
  logic [7:0] rd_rsp_data_i = '0;
  logic busy_o, done_o, fail_o;

  flash_done_poller #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .mode_toggle_i(mode_toggle_i), .exp_data_i(exp_data_i), .timeout_i(timeout_i),
    .rd_req_o(rd_req_o), .rd_ready_i(rd_ready_i), .rd_rsp_valid_i(rd_rsp_valid_i),
    .rd_rsp_data_i(rd_rsp_data_i), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int g_busy, g_glitch, reads;
  logic g_erase;
  logic [7:0] g_exp;
  logic acc_flag = 0, pending = 0, proto_err = 0, prev_stall = 0;
  int lat;

  function automatic logic [7:0] byte_at(int i);
    logic [7:0] t;
    logic [31:0] iv;
    t = g_erase ? 8'hFF : g_exp;
    iv = i;
    if (i == g_glitch) return t ^ 8'h01;
    if (i < g_busy) return {g_erase ? 1'b0 : ~g_exp[7], iv[0], 6'h2A};
    return t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model on the read port, driven at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (prev_stall && !rd_req_o) proto_err = 1;
    if (rd_rsp_valid_i) rd_rsp_valid_i = 0;
    if (acc_flag) begin pending = 1; lat = reads % 3; acc_flag = 0; end
    else if (pending && rd_req_o) proto_err = 1;
    if (pending) begin
      if (lat == 0) begin
        rd_rsp_valid_i = 1; rd_rsp_data_i = byte_at(reads); reads++; pending = 0;
      end else lat--;
    end
    rd_ready_i = (cyc % 4 != 2);
    acc_flag   = rd_req_o && rd_ready_i;
    prev_stall = rd_req_o && !rd_ready_i;
  end

  // expected outcome walked from the requirements: 1 done, 0 fail
  task automatic ref_run(bit er, bit tg, int lim_in, output bit is_done, output int nrd);
    int i = 0, polls = 0, lim;
    bit hp = 0, p6 = 0, app;
    logic [7:0] b, t;
    lim = (lim_in == 0) ? 1 : lim_in;
    t = er ? 8'hFF : g_exp;
    forever begin
      b = byte_at(i); i++; polls++;
      app = tg ? (hp && b[6] == p6) : (er ? b[7] : (b[7] == g_exp[7]));
      p6 = b[6]; hp = 1;
      if (app) begin
        bit ok;
        ok = (byte_at(i) == t) && (byte_at(i+1) == t);
        i += 2;
        if (ok) begin is_done = 1; nrd = i; return; end
        hp = 0;
        if (polls >= lim) begin is_done = 0; nrd = i; return; end
      end else if (polls >= lim) begin is_done = 0; nrd = i; return; end
    end
  endtask

  task automatic run(bit er, bit tg, logic [7:0] ex, int busy, int glitch, int lim);
    bit edone; int erd, n; bit got_done, got_fail, busy_seen;
    g_erase = er; g_exp = ex; g_busy = busy; g_glitch = glitch;
    ref_run(er, tg, lim, edone, erd);
    @(negedge clk);
    reads = 0; proto_err = 0;
    start_i = 1; op_erase_i = er; mode_toggle_i = tg; exp_data_i = ex; timeout_i = lim[TW-1:0];
    @(negedge clk);
    start_i = 0;
    busy_seen = busy_o;
    @(negedge clk);
    if (busy_o) begin  // R2: restart attempt with other parameters while busy
      start_i = 1; op_erase_i = ~er; mode_toggle_i = ~tg; exp_data_i = ~ex; timeout_i = 8'd1;
      @(negedge clk);
      start_i = 0;
    end
    n = 0;
    while (!done_o && !fail_o && n < 400) begin @(negedge clk); n++; end
    got_done = done_o; got_fail = fail_o;
    check(busy_seen, "R2 busy after start", busy_seen, 1);
    check(got_done == edone && got_fail == !edone,
          er ? (tg ? "R6/R7/R9 erase toggle" : "R5/R7/R9 erase dq7")
             : (tg ? "R6/R8/R9 program toggle" : "R4/R8/R9 program dq7"),
          {got_done, got_fail}, edone ? 2 : 1);
    check(reads == erd, "R7 R8 read count", reads, erd);
    check(!busy_o, "R10 idle with result", busy_o, 0);
    @(negedge clk);
    check(!done_o && !fail_o, "R10 single pulse", {done_o, fail_o}, 0);
    check(!proto_err, "R3 one outstanding read", proto_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !rd_req_o && !done_o && !fail_o, "R1 reset state",
          {busy_o, rd_req_o, done_o, fail_o}, 0);
    rst_n = 1;
    for (int er = 0; er < 2; er++)
      for (int tg = 0; tg < 2; tg++)
        for (int e = 0; e < 3; e++)
          for (int b = 0; b < 6; b++)
            for (int g = -1; g < b + 4; g++)
              for (int l = 0; l < 3; l++)
                run(er[0], tg[0], (e == 0) ? 8'h5A : (e == 1) ? 8'hC3 : 8'h81,
                    b, g, (l == 0) ? 1 : (l == 1) ? 3 : 8);
    run(1'b0, 1'b0, 8'h5A, 3, -1, 0);  // R9 limit zero behaves as one
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule